// File: doc/BRIEF.md
# Power-On Reset Sequencer

This block steps a processor-style device out of hard reset. While the external hard reset input is held low, it keeps all of its outputs at their reset values and keeps sampling the configuration inputs. When the reset is released, it freezes the last sample and reports whether that value was held long enough. It then enables the I/O drivers, applies the core clock-generator settings and waits a programmable number of cycles for lock.

If the soft reset input is still asserted when the lock wait ends, the sequencer pauses. Once the soft reset is gone, it releases the core reset and the peripheral resets together. If the latched configuration selects NAND flash boot, it next releases the flash controller and waits for that controller to report its page load. Finally, if enabled, it starts the serial-ROM boot sequencer and waits for it to finish or fail.

A separate sticky request output asks the system for a new hard reset. Three sources set it: a boot sequencer failure, a watchdog expiry with reset enabled, and a software request pulse. Only a hard reset clears it. The clock generator, the flash controller and the serial engine lie outside this block and appear only as handshake inputs.

Top module: `por_sequencer`

## Requirements
- R1: While `hreset_n` is low, every output takes its reset value: state RESET_HOLD, drivers off, all release outputs low and `hreset_req` low. Driving `hreset_n` low in any state returns the block to RESET_HOLD at once, without waiting for a clock. After `hreset_n` rises, the state leaves RESET_HOLD on the third rising clock edge.
- R2: `cfg_latched` holds the `cfg_in` value taken at the last rising edge before the internal release. That is the second rising edge after `hreset_n` rises. `cfg_ok` is 1 only if the last 4 such samples were identical.
- R3: IO_ENABLE lasts exactly one cycle. `io_drive_en` is 1 in every state except RESET_HOLD, and it is high the cycle before `pll_cfg_apply` first rises.
- R4: PLL_LOCK_WAIT lasts max(`lock_cycles`, 1) cycles, using the value present during IO_ENABLE. `pll_cfg_apply` is 1 from PLL_LOCK_WAIT onward.
- R5: If `sreset_n` is low when the lock wait ends, the state moves to SRESET_PAUSE and stays there while `sreset_n` is low. It moves to CORE_RELEASE on the first edge at which `sreset_n` is high.
- R6: `core_rst_n` and `periph_rst_n` rise in the same cycle, on entry to CORE_RELEASE. CORE_RELEASE lasts one cycle, and both signals stay high until a hard reset.
- R7: With NAND boot selected (`cfg_latched[0]` = 1), FCM_LOAD follows CORE_RELEASE. `fcm_rst_n` is 1 from FCM_LOAD onward. The state leaves FCM_LOAD only on an edge at which `fcm_done` is 1.
- R8: With NAND boot not selected, FCM_LOAD is skipped and `fcm_rst_n` stays 0.
- R9: With the boot sequencer enabled (`cfg_latched[1]` = 1), BOOTSEQ_RUN follows. In that state `bootseq_go` is 1, and the state moves to DONE when `bootseq_done` or `bootseq_fail` is 1. With the sequencer disabled, the state goes straight to DONE.
- R10: `hreset_req` rises one cycle after any of these: `bootseq_fail` while in BOOTSEQ_RUN, `wdt_expire` with `wdt_rst_en` = 1, or `sw_req_set`. It then stays high until `hreset_n` is low. A watchdog expiry with `wdt_rst_en` = 0 has no effect.
- R11: Holding `sreset_n` low together with `hreset_n` has no effect on the sequence, provided `sreset_n` is high again before the lock wait ends.
- R12: `state_onehot` has exactly one bit set. The bits, from bit 0 upward, are RESET_HOLD, IO_ENABLE, PLL_LOCK_WAIT, SRESET_PAUSE, CORE_RELEASE, FCM_LOAD, BOOTSEQ_RUN, DONE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal bus clock |
| hreset_n | input | 1 | External hard reset, active low, asserted asynchronously |
| sreset_n | input | 1 | Soft reset, active low |
| cfg_in | input | CFG_W | Configuration straps; bit 0 selects NAND boot, bit 1 enables the boot sequencer |
| lock_cycles | input | CNT_W | Length of the lock wait in cycles |
| fcm_done | input | 1 | Flash controller has finished its page load |
| bootseq_done | input | 1 | Boot sequencer has finished |
| bootseq_fail | input | 1 | Boot sequencer has failed |
| wdt_expire | input | 1 | Watchdog expiry pulse |
| wdt_rst_en | input | 1 | Watchdog expiry requests a reset |
| sw_req_set | input | 1 | Software write that sets the reset request bit |
| cfg_latched | output | CFG_W | Configuration frozen at release |
| cfg_ok | output | 1 | Configuration was stable for at least 4 samples |
| io_drive_en | output | 1 | I/O drivers enabled |
| pll_cfg_apply | output | 1 | Core clock-generator settings applied |
| core_rst_n | output | 1 | Core reset release, active low reset |
| periph_rst_n | output | 1 | Peripheral soft reset release |
| fcm_rst_n | output | 1 | Flash controller reset release |
| bootseq_go | output | 1 | Boot sequencer may run |
| hreset_req | output | 1 | Sticky hard reset request |
| state_onehot | output | 8 | One-hot state indicator |

## Verification
The sequence is run with several setups: the plain path, NAND boot with a slow page load, a boot sequencer that is disabled, and lock lengths of 0, 1 and a larger count. Together these show the skip paths apart from the waiting paths and expose off-by-one errors in the lock timer. Soft reset is applied in two ways. Held past lock completion, it must cause the pause; released during the hard reset, it must leave no trace, which separates the pause condition from a level the block merely remembers. The request sources are driven one at a time, each followed by a hard reset, and a watchdog expiry with reset disabled is included. A hard reset in the middle of the sequence and configuration values that change just before release complete the set.

// File: rtl/por_seq_pkg.sv
`timescale 1ns/100ps
package por_seq_pkg;

    typedef enum logic [2:0] {
        ST_RESET_HOLD    = 3'd0,
        ST_IO_ENABLE     = 3'd1,
        ST_PLL_LOCK_WAIT = 3'd2,
        ST_SRESET_PAUSE  = 3'd3,
        ST_CORE_RELEASE  = 3'd4,
        ST_FCM_LOAD      = 3'd5,
        ST_BOOTSEQ_RUN   = 3'd6,
        ST_DONE          = 3'd7
    } por_state_e;

    localparam int NUM_STATES = 8;

    typedef struct packed {
        por_state_e state;
    } por_fsm_t;

endpackage

// File: rtl/por_cfg_capture.sv
`timescale 1ns/100ps
module por_cfg_capture #(
    parameter int CFG_W      = 8,
    parameter int STABLE_MIN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_in,
    output logic [CFG_W-1:0] cfg_q,
    output logic             cfg_ok
);
    localparam int RUN_W = $clog2(STABLE_MIN + 1);

    typedef struct packed {
        logic [CFG_W-1:0] samp;
        logic [RUN_W-1:0] run;
    } cap_t;

    cap_t cap_d, cap_q;

    // Sampling continues while the block is held; the flops carry no reset
    // so they can watch the straps during the hard reset itself.
    always_comb begin
        cap_d = cap_q;
        if (!rst_n) begin
            cap_d.samp = cfg_in;
            if (cfg_in == cap_q.samp) begin
                if (cap_q.run < RUN_W'(STABLE_MIN))
                    cap_d.run = cap_q.run + RUN_W'(1);
            end else begin
                cap_d.run = RUN_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        cap_q <= cap_d;
    end

    assign cfg_q  = cap_q.samp;
    assign cfg_ok = (cap_q.run >= RUN_W'(STABLE_MIN));

    assert_cfg_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($stable(cfg_q) && $stable(cfg_ok)));

endmodule

// File: rtl/por_lock_timer.sv
`timescale 1ns/100ps
module por_lock_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             expired
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load)
            tmr_d.cnt = load_val;
        else if (run && !expired)
            tmr_d.cnt = tmr_q.cnt - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    // A count of 0 or 1 both mean a single lock cycle.
    assign expired = (tmr_q.cnt <= CNT_W'(1));

    assert_timer_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && !expired) |=> (tmr_q.cnt == $past(tmr_q.cnt) - CNT_W'(1)));

endmodule

// File: rtl/por_reset_request.sv
`timescale 1ns/100ps
module por_reset_request (
    input  logic clk,
    input  logic rst_n,
    input  logic bseq_fail_vld,
    input  logic wdt_expire,
    input  logic wdt_rst_en,
    input  logic sw_req_set,
    output logic req
);
    typedef struct packed {
        logic req;
    } rq_t;

    rq_t rq_d, rq_q;

    always_comb begin
        rq_d = rq_q;
        if (bseq_fail_vld || (wdt_expire && wdt_rst_en) || sw_req_set)
            rq_d.req = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rq_q <= '0;
        else        rq_q <= rq_d;
    end

    assign req = rq_q.req;

    assert_req_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> req);

    assert_wdt_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!req && !bseq_fail_vld && !sw_req_set && !(wdt_expire && wdt_rst_en)) |=> !req);

endmodule

// File: rtl/por_sequencer.sv
`timescale 1ns/100ps
module por_sequencer
    import por_seq_pkg::*;
#(
    parameter int CFG_W      = 8,
    parameter int CNT_W      = 16,
    parameter int STABLE_MIN = 4,
    parameter int NAND_BIT   = 0,
    parameter int BSEQ_BIT   = 1
) (
    input  logic             clk,
    input  logic             hreset_n,
    input  logic             sreset_n,
    input  logic [CFG_W-1:0] cfg_in,
    input  logic [CNT_W-1:0] lock_cycles,
    input  logic             fcm_done,
    input  logic             bootseq_done,
    input  logic             bootseq_fail,
    input  logic             wdt_expire,
    input  logic             wdt_rst_en,
    input  logic             sw_req_set,
    output logic [CFG_W-1:0] cfg_latched,
    output logic             cfg_ok,
    output logic             io_drive_en,
    output logic             pll_cfg_apply,
    output logic             core_rst_n,
    output logic             periph_rst_n,
    output logic             fcm_rst_n,
    output logic             bootseq_go,
    output logic             hreset_req,
    output logic [7:0]       state_onehot
);
    localparam int SYNC_STAGES = 2;

    // Reset synchronizer: asynchronous assertion, synchronous release.
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   rst_n;

    always_ff @(posedge clk or negedge hreset_n) begin
        if (!hreset_n) sync_q <= '0;
        else           sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
    end
    assign rst_n = sync_q[SYNC_STAGES-1];

    por_cfg_capture #(.CFG_W(CFG_W), .STABLE_MIN(STABLE_MIN)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_latched),
        .cfg_ok (cfg_ok)
    );

    por_fsm_t fsm_d, fsm_q;
    logic     lock_expired;
    logic     nand_boot, bseq_en;

    assign nand_boot = cfg_latched[NAND_BIT];
    assign bseq_en   = cfg_latched[BSEQ_BIT];

    por_lock_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (fsm_q.state == ST_IO_ENABLE),
        .load_val (lock_cycles),
        .run      (fsm_q.state == ST_PLL_LOCK_WAIT),
        .expired  (lock_expired)
    );

    por_reset_request u_req (
        .clk           (clk),
        .rst_n         (rst_n),
        .bseq_fail_vld ((fsm_q.state == ST_BOOTSEQ_RUN) && bootseq_fail),
        .wdt_expire    (wdt_expire),
        .wdt_rst_en    (wdt_rst_en),
        .sw_req_set    (sw_req_set),
        .req           (hreset_req)
    );

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.state)
            ST_RESET_HOLD:    fsm_d.state = ST_IO_ENABLE;
            ST_IO_ENABLE:     fsm_d.state = ST_PLL_LOCK_WAIT;
            ST_PLL_LOCK_WAIT:
                if (lock_expired)
                    fsm_d.state = sreset_n ? ST_CORE_RELEASE : ST_SRESET_PAUSE;
            ST_SRESET_PAUSE:
                if (sreset_n) fsm_d.state = ST_CORE_RELEASE;
            ST_CORE_RELEASE:
                if (nand_boot)    fsm_d.state = ST_FCM_LOAD;
                else if (bseq_en) fsm_d.state = ST_BOOTSEQ_RUN;
                else              fsm_d.state = ST_DONE;
            ST_FCM_LOAD:
                if (fcm_done) fsm_d.state = bseq_en ? ST_BOOTSEQ_RUN : ST_DONE;
            ST_BOOTSEQ_RUN:
                if (bootseq_done || bootseq_fail) fsm_d.state = ST_DONE;
            ST_DONE:          fsm_d.state = ST_DONE;
            default:          fsm_d.state = ST_RESET_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q.state <= ST_RESET_HOLD;
        else        fsm_q       <= fsm_d;
    end

    // Output decode from the registered state.
    logic released;
    assign released      = (fsm_q.state >= ST_CORE_RELEASE);
    assign io_drive_en   = (fsm_q.state != ST_RESET_HOLD);
    assign pll_cfg_apply = (fsm_q.state >= ST_PLL_LOCK_WAIT);
    assign core_rst_n    = released;
    assign periph_rst_n  = released;
    assign fcm_rst_n     = nand_boot && (fsm_q.state >= ST_FCM_LOAD);
    assign bootseq_go    = (fsm_q.state == ST_BOOTSEQ_RUN);

    genvar gi;
    generate
        for (gi = 0; gi < NUM_STATES; gi++) begin : g_onehot
            assign state_onehot[gi] = (fsm_q.state == por_state_e'(gi));
        end
    endgenerate

    assert_onehot_R12: assert property (@(posedge clk)
        $countones(state_onehot) == 1);

    assert_hold_in_reset_R1: assert property (@(posedge clk)
        !rst_n |-> (state_onehot == 8'h01 && !io_drive_en && !hreset_req));

    assert_io_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_cfg_apply) |-> $past(io_drive_en));

    assert_pause_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.state == ST_SRESET_PAUSE && !sreset_n) |=> (fsm_q.state == ST_SRESET_PAUSE));

    assert_release_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_rst_n) |-> ($past(fsm_q.state) == ST_PLL_LOCK_WAIT ||
                               $past(fsm_q.state) == ST_SRESET_PAUSE));

    assert_fcm_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.state == ST_FCM_LOAD && !fcm_done) |=> !bootseq_go);

    assert_fcm_after_core_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fcm_rst_n) |-> $past(core_rst_n));

endmodule

// File: tb/por_sequencer_tb_top.sv
`timescale 1ns/100ps
module por_sequencer_tb_top;

    logic       clk = 1'b0;
    logic       hreset_n = 1'b0;
    logic       sreset_n = 1'b1;
    logic [7:0] cfg_in = 8'h02;
    logic [15:0] lock_cycles = 16'd20;
    logic       fcm_done = 1'b0, bootseq_done = 1'b0, bootseq_fail = 1'b0;
    logic       wdt_expire = 1'b0, wdt_rst_en = 1'b0, sw_req_set = 1'b0;

    logic [7:0] cfg_latched, state_onehot;
    logic cfg_ok, io_drive_en, pll_cfg_apply, core_rst_n, periph_rst_n;
    logic fcm_rst_n, bootseq_go, hreset_req;

    always #2.5 clk = ~clk;

    por_sequencer dut_i (
        .clk(clk), .hreset_n(hreset_n), .sreset_n(sreset_n), .cfg_in(cfg_in),
        .lock_cycles(lock_cycles), .fcm_done(fcm_done), .bootseq_done(bootseq_done),
        .bootseq_fail(bootseq_fail), .wdt_expire(wdt_expire), .wdt_rst_en(wdt_rst_en),
        .sw_req_set(sw_req_set), .cfg_latched(cfg_latched), .cfg_ok(cfg_ok),
        .io_drive_en(io_drive_en), .pll_cfg_apply(pll_cfg_apply), .core_rst_n(core_rst_n),
        .periph_rst_n(periph_rst_n), .fcm_rst_n(fcm_rst_n), .bootseq_go(bootseq_go),
        .hreset_req(hreset_req), .state_onehot(state_onehot)
    );

    int n_cmp = 0, n_bad = 0, cycles = 0;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    int m_rel = 0, m_state = 0, m_left = 0;
    logic m_req = 1'b0;
    logic [7:0] hist[$];

    function automatic logic [7:0] m_cfg();
        return (hist.size() == 0) ? 8'h00 : hist[hist.size()-1];
    endfunction
    function automatic logic m_ok();
        if (hist.size() < 4) return 1'b0;
        foreach (hist[i]) if (hist[i] != hist[0]) return 1'b0;
        return 1'b1;
    endfunction

    always @(posedge clk) begin
        if (m_rel < 2) begin
            hist.push_back(cfg_in);
            if (hist.size() > 4) void'(hist.pop_front());
        end
    end

    always @(posedge clk or negedge hreset_n) begin
        if (!hreset_n) begin
            m_rel <= 0; m_state <= 0; m_req <= 1'b0;
        end else begin
            if (m_rel < 2) m_rel <= m_rel + 1;
            if (m_rel >= 2 && ((m_state == 6 && bootseq_fail) || (wdt_expire && wdt_rst_en) || sw_req_set))
                m_req <= 1'b1;
            case (m_state)
                0: if (m_rel >= 2) m_state <= 1;
                1: begin m_state <= 2; m_left <= (lock_cycles == 0) ? 1 : int'(lock_cycles); end
                2: if (m_left <= 1) m_state <= sreset_n ? 4 : 3; else m_left <= m_left - 1;
                3: if (sreset_n) m_state <= 4;
                4: m_state <= m_cfg()[0] ? 5 : (m_cfg()[1] ? 6 : 7);
                5: if (fcm_done) m_state <= m_cfg()[1] ? 6 : 7;
                6: if (bootseq_done || bootseq_fail) m_state <= 7;
                default: m_state <= 7;
            endcase
        end
    end

    always @(negedge clk) begin
        #1;
        chk("R12 state", {8'h0, state_onehot}, {8'h0, 8'h01 << m_state});
        chk("R1/R3 io_drive_en", {15'h0, io_drive_en}, {15'h0, m_state != 0});
        chk("R4 pll_cfg_apply", {15'h0, pll_cfg_apply}, {15'h0, m_state >= 2});
        chk("R6 core_rst_n", {15'h0, core_rst_n}, {15'h0, m_state >= 4});
        chk("R6 periph_rst_n", {15'h0, periph_rst_n}, {15'h0, m_state >= 4});
        chk("R7/R8 fcm_rst_n", {15'h0, fcm_rst_n}, {15'h0, m_cfg()[0] && m_state >= 5});
        chk("R9 bootseq_go", {15'h0, bootseq_go}, {15'h0, m_state == 6});
        chk("R10 hreset_req", {15'h0, hreset_req}, {15'h0, m_req});
        if (m_state != 0) begin
            chk("R2 cfg_latched", {8'h0, cfg_latched}, {8'h0, m_cfg()});
            chk("R2 cfg_ok", {15'h0, cfg_ok}, {15'h0, m_ok()});
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic boot(input logic [7:0] cfg, input logic [15:0] lk);
        @(negedge clk);
        hreset_n = 1'b0; cfg_in = cfg; lock_cycles = lk;
        cyc(8);
        hreset_n = 1'b1;
    endtask

    task automatic wait_st(input int s);
        for (int i = 0; i < 2000 && state_onehot != (8'h01 << s); i++) @(negedge clk);
    endtask

    task automatic count_lock(input int exp_len);
        int len = 0;
        wait_st(2);
        while (state_onehot[2]) begin len++; @(negedge clk); end
        chk("R4 lock length", 16'(len), 16'(exp_len));
    endtask

    initial begin : watchdog
        for (int i = 0; i < 100000; i++) begin @(posedge clk); cycles++; end
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        cyc(6);
        // R1: reset state
        chk("R1 reset state", {8'h0, state_onehot}, 16'h0001);
        chk("R1 reset hreset_req", {15'h0, hreset_req}, 16'h0);

        // Plain path: no NAND, boot sequencer on, lock 20
        boot(8'h02, 16'd20);
        count_lock(20);
        wait_st(6);
        cyc(3); bootseq_done = 1'b1; cyc(1); bootseq_done = 1'b0;
        cyc(2);
        chk("R9 done reached", {8'h0, state_onehot}, 16'h0080);
        chk("R8 fcm held", {15'h0, fcm_rst_n}, 16'h0);

        // NAND boot, soft reset held past lock, slow page load
        boot(8'h03, 16'd5);
        sreset_n = 1'b0;
        wait_st(3); cyc(6);
        chk("R5 pause held", {8'h0, state_onehot}, 16'h0008);
        sreset_n = 1'b1;
        wait_st(5); cyc(10);
        chk("R7 waiting for fcm", {15'h0, bootseq_go}, 16'h0);
        fcm_done = 1'b1; cyc(1); fcm_done = 1'b0;
        wait_st(6); cyc(2);
        bootseq_fail = 1'b1; cyc(1); bootseq_fail = 1'b0;
        cyc(2);
        chk("R10 fail request", {15'h0, hreset_req}, 16'h1);

        // Soft reset only during hard reset; lock 0; sequencer off
        begin
            logic saw_pause = 1'b0;
            @(negedge clk); hreset_n = 1'b0; sreset_n = 1'b0; cfg_in = 8'h00; lock_cycles = 16'd0;
            cyc(8); hreset_n = 1'b1; cyc(1); sreset_n = 1'b1;
            for (int i = 0; i < 12; i++) begin if (state_onehot[3]) saw_pause = 1'b1; @(negedge clk); end
            chk("R11 no pause", {15'h0, saw_pause}, 16'h0);
            chk("R9 skip to done", {8'h0, state_onehot}, 16'h0080);
        end

        // Lock of 1, masked watchdog, then enabled watchdog
        boot(8'h00, 16'd1);
        count_lock(1);
        wdt_expire = 1'b1; wdt_rst_en = 1'b0; cyc(1); wdt_expire = 1'b0; cyc(2);
        chk("R10 masked wdt", {15'h0, hreset_req}, 16'h0);
        wdt_rst_en = 1'b1; wdt_expire = 1'b1; cyc(1); wdt_expire = 1'b0; wdt_rst_en = 1'b0; cyc(2);
        chk("R10 wdt request", {15'h0, hreset_req}, 16'h1);

        // Software request, then hard reset in mid-lock; unstable config
        boot(8'h02, 16'd40);
        wait_st(2); cyc(3);
        sw_req_set = 1'b1; cyc(1); sw_req_set = 1'b0; cyc(1);
        chk("R10 sw request", {15'h0, hreset_req}, 16'h1);
        hreset_n = 1'b0; #1;
        chk("R1 async return", {8'h0, state_onehot}, 16'h0001);
        cyc(6);
        cfg_in = 8'h06; hreset_n = 1'b1;
        wait_st(1); cyc(1);
        chk("R2 unstable cfg", {15'h0, cfg_ok}, 16'h0);
        chk("R2 latched value", {8'h0, cfg_latched}, 16'h0006);
        wait_st(6); bootseq_done = 1'b1; cyc(1); bootseq_done = 1'b0; cyc(2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule